// File: doc/BRIEF.md
# MDIO Paged Wide-Register Bridge

This block is a management slave on a shared MDC/MDIO bus. It gives a host access to a bank of 32-bit internal registers while using only 16-bit Clause 22 read and write frames. It responds only to frames that carry its own PHY address. That address comes from strap pins, so several such devices can share one bus without clashing.

A wide access takes three frames. The host first writes a page register, which supplies the upper internal address bits. It then moves the low data half through an ordinary register number, whose low bits select the word within the page. Last, it moves the high data half through a dedicated register.

Writes are held in a pending buffer and reach the internal register file as a single 32-bit write when the high half arrives. A low-half read captures the whole word in a snapshot, so a later high-half read returns the upper half of that same word. The register-file port is synchronous to MDC. A read strobe returns data one cycle later.

Top module: `mdio_reg_bridge`

## Requirements
- R1: A frame whose 5-bit PHY address differs from `phy_strap` causes no register-file strobe, no change to the page and no drive of MDIO.
- R2: The PHY address the block answers to is the current value of `phy_strap`. After the strap changes, frames to the new value are served and frames to the old value are ignored.
- R3: A write to register number 0x1F loads the page with data bits PAGE_W-1:0, and higher data bits are dropped. A read of 0x1F returns the page zero-extended to 16 bits.
- R4: The internal address of a low-half access is {page, register number bits 3:0, 2'b00}. Register numbers 0x10 and 0x1F are never used as low indexes.
- R5: A write to any register number other than 0x10 and 0x1F only fills a pending buffer with its data and address. The next write to 0x10 then issues exactly one `reg_wr` pulse carrying {high data, low data} to the buffered address, even if the page changed in between.
- R6: A write to 0x10 when no low half is pending produces no `reg_wr` pulse.
- R7: A read of a low register number issues one `reg_rd` pulse, and the frame returns bits 15:0 of `reg_rdata` as it stands the cycle after that pulse.
- R8: A read of 0x10 issues no `reg_rd`. It returns bits 31:16 of the word captured by the most recent low-half read, even if the internal word has since changed.
- R9: During a read, MDIO is released for the first turnaround bit, driven 0 on the second, and then carries 16 data bits MSB first. It is released again once the data bits end, and it is never driven outside a read.
- R10: A frame is accepted only after at least 32 consecutive ones, then start bits 0,1. A frame with 31 preamble ones has no effect.
- R11: A frame with opcode 00 or 11 has no effect. Opcode 01 is a write and 10 is a read.
- R12: After reset, `mdio_oe`, `reg_rd` and `reg_wr` are low, the page is 0 and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; MDIO is sampled and driven on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdio_in | input | 1 | Value seen on the MDIO line |
| mdio_out | output | 1 | Value driven onto MDIO when enabled |
| mdio_oe | output | 1 | Drive enable for MDIO |
| phy_strap | input | 5 | Strap-selected PHY address |
| reg_addr | output | PAGE_W+6 | Internal register byte address |
| reg_rd | output | 1 | One-cycle read strobe; data expected the next cycle |
| reg_wr | output | 1 | One-cycle 32-bit write strobe |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data, valid the cycle after `reg_rd` |

## Verification
The bench builds the block with its default widths: PAGE_W of 10 and IDX_W of 4, which gives a 16-bit internal address. With these values a page write of 0xFFFF shows the truncation to ten bits. The top page value combined with index 0xE from register number 0x1E then puts the address at the upper end of the space. The bench compares wide words through a behavioural memory. It also counts the strobes at the port, so it can tell a deferred write, a dropped write and a snapshot read apart.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;

    typedef enum logic [2:0] {
        FS_PRE,
        FS_START,
        FS_HDR,
        FS_TA,
        FS_DATA
    } fsm_e;

    localparam logic [1:0] OP_WR   = 2'b01;
    localparam logic [1:0] OP_RD   = 2'b10;
    localparam logic [4:0] RN_HIGH = 5'h10;
    localparam logic [4:0] RN_PAGE = 5'h1F;
    localparam int         HALF_W  = 16;
    localparam int         WORD_W  = 32;

endpackage

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_bridge_pkg::*;
#(
    parameter int PRE_MIN = 32
) (
    input  logic              mdc,
    input  logic              rst_n,
    input  logic              mdio_in,
    input  logic [4:0]        phy_addr,
    input  logic [HALF_W-1:0] ld_word,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic              hdr_go,
    output logic              hdr_rd,
    output logic [4:0]        hdr_reg,
    output logic              ld_go,
    output logic              wr_go,
    output logic [HALF_W-1:0] wr_data
);

    localparam int PRE_W = $clog2(PRE_MIN + 1);

    typedef struct packed {
        fsm_e              st;
        logic [PRE_W-1:0]  pre;
        logic [4:0]        cnt;
        logic [10:0]       hdr;
        logic              rd;
        logic [HALF_W-1:0] sh;
        logic              oe;
        logic              out;
    } eng_s;

    eng_s        q, n;
    logic [11:0] full;

    always_comb begin
        n       = q;
        hdr_go  = 1'b0;
        hdr_rd  = 1'b0;
        hdr_reg = '0;
        ld_go   = 1'b0;
        wr_go   = 1'b0;
        wr_data = {q.sh[HALF_W-2:0], mdio_in};
        full    = {q.hdr, mdio_in};
        case (q.st)
            FS_PRE: begin
                if (mdio_in) begin
                    if (q.pre != PRE_W'(PRE_MIN)) n.pre = q.pre + 1'b1;
                end else begin
                    if (q.pre == PRE_W'(PRE_MIN)) n.st = FS_START;
                    n.pre = '0;
                end
            end
            FS_START: begin
                n.cnt = '0;
                n.st  = mdio_in ? FS_HDR : FS_PRE;
            end
            FS_HDR: begin
                n.hdr = full[10:0];
                n.cnt = q.cnt + 5'd1;
                if (q.cnt == 5'd11) begin
                    n.cnt = '0;
                    if ((full[11:10] == OP_WR || full[11:10] == OP_RD) &&
                        full[9:5] == phy_addr) begin
                        n.st    = FS_TA;
                        n.rd    = (full[11:10] == OP_RD);
                        hdr_go  = 1'b1;
                        hdr_rd  = (full[11:10] == OP_RD);
                        hdr_reg = full[4:0];
                    end else begin
                        n.st = FS_PRE;
                    end
                end
            end
            FS_TA: begin
                n.cnt = q.cnt + 5'd1;
                if (q.cnt == 5'd0) begin
                    if (q.rd) begin
                        n.oe  = 1'b1;
                        n.out = 1'b0;
                    end
                end else begin
                    n.st  = FS_DATA;
                    n.cnt = '0;
                    if (q.rd) begin
                        ld_go = 1'b1;
                        n.out = ld_word[HALF_W-1];
                        n.sh  = {ld_word[HALF_W-2:0], 1'b0};
                    end
                end
            end
            FS_DATA: begin
                n.cnt = q.cnt + 5'd1;
                if (q.rd) begin
                    if (q.cnt == 5'd15) begin
                        n.oe  = 1'b0;
                        n.out = 1'b0;
                    end else begin
                        n.out = q.sh[HALF_W-1];
                        n.sh  = {q.sh[HALF_W-2:0], 1'b0};
                    end
                end else begin
                    n.sh = wr_data;
                end
                if (q.cnt == 5'd15) begin
                    n.st  = FS_PRE;
                    n.pre = '0;
                    n.rd  = 1'b0;
                    wr_go = !q.rd;
                end
            end
            default: n.st = FS_PRE;
        endcase
    end

    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= FS_PRE;
            q.pre <= '0;
            q.cnt <= '0;
            q.hdr <= '0;
            q.rd  <= 1'b0;
            q.sh  <= '0;
            q.oe  <= 1'b0;
            q.out <= 1'b0;
        end else begin
            q <= n;
        end
    end

    assign mdio_out = q.out;
    assign mdio_oe  = q.oe;

    // R9: drive only inside the turnaround/data window of a read
    a_r9_oe_in_read: assert property (@(posedge mdc) disable iff (!rst_n)
        mdio_oe |-> (q.rd && (q.st == FS_TA || q.st == FS_DATA)));

    // R9: the first driven bit is the turnaround zero
    a_r9_ta_zero: assert property (@(posedge mdc) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_out);

    // R9: the line is released while hunting for a preamble
    a_r9_release_idle: assert property (@(posedge mdc) disable iff (!rst_n)
        (q.st == FS_PRE) |-> !mdio_oe);

endmodule

// File: rtl/mdio_page_bank.sv
module mdio_page_bank
    import mdio_bridge_pkg::*;
#(
    parameter int PAGE_W = 10,
    parameter int IDX_W  = 4
) (
    input  logic                       mdc,
    input  logic                       rst_n,
    input  logic                       hdr_go,
    input  logic                       hdr_rd,
    input  logic [4:0]                 hdr_reg,
    input  logic                       ld_go,
    input  logic                       wr_go,
    input  logic [HALF_W-1:0]          wr_data,
    output logic [HALF_W-1:0]          ld_word,
    output logic [PAGE_W+IDX_W+1:0]    reg_addr,
    output logic                       reg_rd,
    output logic                       reg_wr,
    output logic [WORD_W-1:0]          reg_wdata,
    input  logic [WORD_W-1:0]          reg_rdata
);

    localparam int ADDR_W = PAGE_W + IDX_W + 2;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [4:0]        cur_reg;
        logic              pend_vld;
        logic [ADDR_W-1:0] pend_addr;
        logic [HALF_W-1:0] pend_lo;
        logic [WORD_W-1:0] snap;
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } bank_s;

    bank_s             q, n;
    logic [ADDR_W-1:0] hdr_addr;
    logic [ADDR_W-1:0] cur_addr;
    logic [HALF_W-1:0] page_ext;
    logic              cur_low;
    logic              hdr_low;

    always_comb begin
        n        = q;
        n.rd     = 1'b0;
        n.wr     = 1'b0;
        hdr_addr = {q.page, hdr_reg[IDX_W-1:0], 2'b00};
        cur_addr = {q.page, q.cur_reg[IDX_W-1:0], 2'b00};
        hdr_low  = (hdr_reg != RN_HIGH) && (hdr_reg != RN_PAGE);
        cur_low  = (q.cur_reg != RN_HIGH) && (q.cur_reg != RN_PAGE);
        page_ext = '0;
        page_ext[PAGE_W-1:0] = q.page;

        case (q.cur_reg)
            RN_PAGE: ld_word = page_ext;
            RN_HIGH: ld_word = q.snap[WORD_W-1:HALF_W];
            default: ld_word = reg_rdata[HALF_W-1:0];
        endcase

        if (hdr_go) begin
            n.cur_reg = hdr_reg;
            if (hdr_rd && hdr_low) begin
                n.rd   = 1'b1;
                n.addr = hdr_addr;
            end
        end

        if (ld_go && cur_low) n.snap = reg_rdata;

        if (wr_go) begin
            case (q.cur_reg)
                RN_PAGE: n.page = wr_data[PAGE_W-1:0];
                RN_HIGH: begin
                    if (q.pend_vld) begin
                        n.wr       = 1'b1;
                        n.addr     = q.pend_addr;
                        n.wdata    = {wr_data, q.pend_lo};
                        n.pend_vld = 1'b0;
                    end
                end
                default: begin
                    n.pend_vld  = 1'b1;
                    n.pend_addr = cur_addr;
                    n.pend_lo   = wr_data;
                end
            endcase
        end
    end

    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign reg_addr  = q.addr;
    assign reg_rd    = q.rd;
    assign reg_wr    = q.wr;
    assign reg_wdata = q.wdata;

    // R7: read strobe lasts a single cycle
    a_r7_rd_pulse: assert property (@(posedge mdc) disable iff (!rst_n)
        reg_rd |=> !reg_rd);

    // R5: every internal write follows a buffered low half
    a_r5_wr_needs_pending: assert property (@(posedge mdc) disable iff (!rst_n)
        reg_wr |-> $past(q.pend_vld));

    // R5: write strobe lasts a single cycle
    a_r5_wr_pulse: assert property (@(posedge mdc) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    // R8: the snapshot only moves when a read frame loads its data
    a_r8_snap_hold: assert property (@(posedge mdc) disable iff (!rst_n)
        !$past(ld_go) |-> $stable(q.snap));

    // R7: read and write strobes never overlap
    a_r7_no_overlap: assert property (@(posedge mdc) disable iff (!rst_n)
        !(reg_rd && reg_wr));

endmodule

// File: rtl/mdio_reg_bridge.sv
module mdio_reg_bridge
    import mdio_bridge_pkg::*;
#(
    parameter  int PAGE_W = 10,
    parameter  int IDX_W  = 4,
    localparam int ADDR_W = PAGE_W + IDX_W + 2
) (
    input  logic              mdc,
    input  logic              rst_n,
    input  logic              mdio_in,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic [4:0]        phy_strap,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [31:0]       reg_wdata,
    input  logic [31:0]       reg_rdata
);

    logic              hdr_go;
    logic              hdr_rd;
    logic [4:0]        hdr_reg;
    logic              ld_go;
    logic              wr_go;
    logic [HALF_W-1:0] wr_data;
    logic [HALF_W-1:0] ld_word;

    mdio_frame_engine #(.PRE_MIN(32)) u_engine (
        .mdc      (mdc),
        .rst_n    (rst_n),
        .mdio_in  (mdio_in),
        .phy_addr (phy_strap),
        .ld_word  (ld_word),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe),
        .hdr_go   (hdr_go),
        .hdr_rd   (hdr_rd),
        .hdr_reg  (hdr_reg),
        .ld_go    (ld_go),
        .wr_go    (wr_go),
        .wr_data  (wr_data)
    );

    mdio_page_bank #(.PAGE_W(PAGE_W), .IDX_W(IDX_W)) u_bank (
        .mdc       (mdc),
        .rst_n     (rst_n),
        .hdr_go    (hdr_go),
        .hdr_rd    (hdr_rd),
        .hdr_reg   (hdr_reg),
        .ld_go     (ld_go),
        .wr_go     (wr_go),
        .wr_data   (wr_data),
        .ld_word   (ld_word),
        .reg_addr  (reg_addr),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

endmodule

// File: tb/mdio_reg_bridge_test.sv
module mdio_reg_bridge_test;

    localparam int CLK_PERIOD = 10;

    logic        mdc = 1'b0;
    logic        rst_n = 1'b0;
    logic        mdio_in = 1'b1;
    logic        mdio_out, mdio_oe;
    logic [4:0]  phy_strap = 5'h05;
    logic [15:0] reg_addr;
    logic        reg_rd, reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata = '0;

    int checks = 0;
    int errors = 0;
    int wr_count = 0;
    int rd_count = 0;
    logic [15:0] last_waddr = '0;
    logic [31:0] mem [int unsigned];

    always #(CLK_PERIOD/2) mdc = ~mdc;

    mdio_reg_bridge uut (
        .mdc(mdc), .rst_n(rst_n), .mdio_in(mdio_in), .mdio_out(mdio_out),
        .mdio_oe(mdio_oe), .phy_strap(phy_strap), .reg_addr(reg_addr),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    function automatic logic [31:0] mem_get(logic [15:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return {16'hA5A5, a};
    endfunction

    always @(posedge mdc) begin
        if (reg_rd) begin
            reg_rdata <= mem_get(reg_addr);
            rd_count  <= rd_count + 1;
        end
        if (reg_wr) begin
            mem[int'(reg_addr)] = reg_wdata;
            last_waddr <= reg_addr;
            wr_count   <= wr_count + 1;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_bit(logic b);
        @(negedge mdc);
        mdio_in = b;
    endtask

    task automatic idle(int n);
        repeat (n) send_bit(1'b1);
    endtask

    task automatic send_head(int pre, logic [1:0] op, logic [4:0] phy, logic [4:0] rn);
        repeat (pre) send_bit(1'b1);
        send_bit(1'b0); send_bit(1'b1);
        for (int i = 1; i >= 0; i--) send_bit(op[i]);
        for (int i = 4; i >= 0; i--) send_bit(phy[i]);
        for (int i = 4; i >= 0; i--) send_bit(rn[i]);
    endtask

    task automatic send_frame(int pre, logic [1:0] op, logic [4:0] phy,
                              logic [4:0] rn, logic [15:0] data);
        send_head(pre, op, phy, rn);
        send_bit(1'b1); send_bit(1'b0);
        for (int i = 15; i >= 0; i--) send_bit(data[i]);
        idle(4);
    endtask

    task automatic mdio_wr(logic [4:0] phy, logic [4:0] rn, logic [15:0] data);
        send_frame(32, 2'b01, phy, rn, data);
    endtask

    task automatic mdio_rd(logic [4:0] phy, logic [4:0] rn,
                           output logic [15:0] val, output logic ta_ok);
        logic ta1, ta2, all_oe, rel;
        send_head(32, 2'b10, phy, rn);
        @(negedge mdc); ta1 = mdio_oe; mdio_in = 1'b1;
        @(negedge mdc); ta2 = mdio_oe && !mdio_out;
        all_oe = 1'b1;
        val = '0;
        for (int i = 0; i < 16; i++) begin
            @(negedge mdc);
            val = {val[14:0], mdio_oe ? mdio_out : 1'b1};
            all_oe &= mdio_oe;
        end
        @(negedge mdc); rel = !mdio_oe;
        ta_ok = !ta1 && ta2 && all_oe && rel;
        idle(3);
    endtask

    function automatic logic [15:0] wide_addr(logic [9:0] pg, logic [4:0] rn);
        return {pg, rn[3:0], 2'b00};
    endfunction

    task automatic t_reset;
        logic [15:0] v; logic ok;
        check("R12 oe after reset", {31'd0, mdio_oe}, 32'd0);
        check("R12 rd strobe after reset", {31'd0, reg_rd}, 32'd0);
        check("R12 wr strobe after reset", {31'd0, reg_wr}, 32'd0);
        mdio_rd(phy_strap, 5'h1F, v, ok);
        check("R12 page after reset", {16'd0, v}, 32'd0);
        mdio_wr(phy_strap, 5'h10, 16'h1111);
        check("R12 no pending after reset", wr_count, 0);
    endtask

    task automatic t_write32;
        int w0;
        w0 = wr_count;
        mdio_wr(phy_strap, 5'h1F, 16'h0155);
        mdio_wr(phy_strap, 5'h07, 16'hBEEF);
        check("R5 low write deferred", wr_count, w0);
        mdio_wr(phy_strap, 5'h10, 16'hCAFE);
        check("R5 one wide write", wr_count, w0 + 1);
        check("R4 wide write address", {16'd0, last_waddr}, {16'd0, wide_addr(10'h155, 5'h07)});
        check("R5 wide write data", mem_get(wide_addr(10'h155, 5'h07)), 32'hCAFEBEEF);
    endtask

    task automatic t_no_pending;
        int w0;
        w0 = wr_count;
        mdio_wr(phy_strap, 5'h10, 16'h7777);
        check("R6 high write without pending", wr_count, w0);
    endtask

    task automatic t_pending_page;
        mdio_wr(phy_strap, 5'h1F, 16'h03FF);
        mdio_wr(phy_strap, 5'h1E, 16'h0102);
        mdio_wr(phy_strap, 5'h1F, 16'h0001);
        mdio_wr(phy_strap, 5'h10, 16'h0304);
        check("R5 buffered address survives page change", {16'd0, last_waddr},
              {16'd0, wide_addr(10'h3FF, 5'h1E)});
        check("R4 top index data", mem_get(16'hFFF8), 32'h03040102);
    endtask

    task automatic t_read32;
        logic [15:0] v; logic ok; int r0; logic [15:0] a;
        a = wide_addr(10'h2A3, 5'h09);
        mem[int'(a)] = 32'h12345678;
        mdio_wr(phy_strap, 5'h1F, 16'h02A3);
        r0 = rd_count;
        mdio_rd(phy_strap, 5'h09, v, ok);
        check("R7 low read data", {16'd0, v}, 32'h5678);
        check("R7 one read strobe", rd_count, r0 + 1);
        check("R9 turnaround and release on low read", {31'd0, ok}, 32'd1);
        mem[int'(a)] = 32'h0;
        mdio_rd(phy_strap, 5'h10, v, ok);
        check("R8 high half from snapshot", {16'd0, v}, 32'h1234);
        check("R8 no strobe on high read", rd_count, r0 + 1);
        check("R9 turnaround and release on high read", {31'd0, ok}, 32'd1);
    endtask

    task automatic t_page_rb;
        logic [15:0] v; logic ok;
        mdio_wr(phy_strap, 5'h1F, 16'hFFFF);
        mdio_rd(phy_strap, 5'h1F, v, ok);
        check("R3 page truncated and read back", {16'd0, v}, 32'h03FF);
        mdio_wr(phy_strap, 5'h1F, 16'h0042);
        mdio_rd(phy_strap, 5'h1F, v, ok);
        check("R3 page readback", {16'd0, v}, 32'h0042);
    endtask

    task automatic t_foreign;
        logic [15:0] v; logic ok; int r0;
        r0 = rd_count;
        mdio_wr(phy_strap ^ 5'h01, 5'h1F, 16'h0099);
        mdio_rd(phy_strap ^ 5'h01, 5'h03, v, ok);
        check("R1 foreign read leaves line released", {16'd0, v}, 32'hFFFF);
        check("R1 foreign read no strobe", rd_count, r0);
        mdio_rd(phy_strap, 5'h1F, v, ok);
        check("R1 foreign write leaves page", {16'd0, v}, 32'h0042);
    endtask

    task automatic t_strap;
        logic [15:0] v; logic ok; logic [4:0] old_addr;
        old_addr = phy_strap;
        phy_strap = 5'h1A;
        mdio_wr(5'h1A, 5'h1F, 16'h0123);
        mdio_wr(old_addr, 5'h1F, 16'h0077);
        mdio_rd(5'h1A, 5'h1F, v, ok);
        check("R2 new strap address served", {16'd0, v}, 32'h0123);
    endtask

    task automatic t_short_pre;
        logic [15:0] v; logic ok;
        mdio_in = 1'b0;
        idle(0);
        send_bit(1'b0);
        send_frame(31, 2'b01, phy_strap, 5'h1F, 16'h0200);
        mdio_rd(phy_strap, 5'h1F, v, ok);
        check("R10 short preamble ignored", {16'd0, v}, 32'h0123);
    endtask

    task automatic t_bad_op;
        logic [15:0] v; logic ok;
        send_frame(32, 2'b11, phy_strap, 5'h1F, 16'h0311);
        send_frame(32, 2'b00, phy_strap, 5'h1F, 16'h0322);
        mdio_rd(phy_strap, 5'h1F, v, ok);
        check("R11 bad opcodes ignored", {16'd0, v}, 32'h0123);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (4) @(negedge mdc);
        rst_n = 1'b1;
        @(negedge mdc);
        t_reset;
        t_write32;
        t_no_pending;
        t_pending_page;
        t_read32;
        t_page_rb;
        t_foreign;
        t_strap;
        t_short_pre;
        t_bad_op;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge mdc);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule